// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a translation miss in hardware. Given a virtual page number, an access type (read or write) and a privilege mode (user or kernel), it walks a forward-mapped page table of three levels held in memory. It starts at a table base supplied by the caller and issues one memory read per level over a simple request/response port. A successful walk ends with a one-cycle completion pulse that carries the physical frame number and the permission bits of the leaf entry. A failed walk ends with a one-cycle fault pulse that carries a fault code and the level at which the walk stopped.

The virtual page number is 30 bits wide: three 10-bit indices, most significant first, above a 13-bit page offset that the walker never sees. Pages are therefore 8 KB, and each 1024-entry table of 8-byte entries fills exactly one page. Only one walk runs at a time. A caller offers a request when `req_ready` is high and must wait for the result pulse before the next walk can start.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `done_valid` and `fault_valid` are all low and `req_ready` is high.
- R2: The entry address for a level is that level's table base plus its 10-bit index times 8. Level 1 uses `vpn[29:20]` and a base equal to `ptbr` as sampled in the acceptance cycle, level 2 uses `vpn[19:10]`, and level 3 uses `vpn[9:0]`.
- R3: The table base for levels 2 and 3 is the frame number of the entry one level up (entry bits [58:32]), shifted left by 13.
- R4: A walk issues exactly one read per level, in order from level 1 to level 3. A request that is not taken holds its address unchanged until `mem_req_ready` is high.
- R5: An entry with bit 0 (present) clear ends the walk at once with fault code 1 (absent) and that level (1, 2 or 3) in `fault_level`. No further read is issued.
- R6: A read is granted only when the leaf's read enable for the current mode is set: bit 1 in kernel mode and bit 3 in user mode. Otherwise the walk ends with fault code 2 at level 3.
- R7: A write is granted only when the leaf's write enable for the current mode is set: bit 2 in kernel mode and bit 4 in user mode. Otherwise the walk ends with fault code 3 at level 3. The read enables play no part in a write.
- R8: A granted access raises `done_valid` with `done_pfn` equal to leaf bits [58:32] and `done_perm` equal to leaf bits [4:1] (user write, user read, kernel write, kernel read).
- R9: `busy` is high and `req_ready` low from the cycle after acceptance until the result pulse. A request offered while busy, together with any change of `ptbr`, has no effect on the running walk.
- R10: Each result pulse lasts exactly one cycle, and `done_valid` and `fault_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vpn | input | 30 | Virtual page number (three 10-bit indices) |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| ptbr | input | 40 | Physical base of the level-1 table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 40 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Table entry |
| done_valid | output | 1 | Walk succeeded (one-cycle pulse) |
| done_pfn | output | 27 | Translated frame number |
| done_perm | output | 4 | Leaf permission bits {uw, ur, kw, kr} |
| fault_valid | output | 1 | Walk failed (one-cycle pulse) |
| fault_code | output | 2 | 1 absent, 2 read denied, 3 write denied |
| fault_level | output | 2 | Level (1 to 3) at which the walk stopped |

## Verification
A request taken at a clock edge makes `busy` visible in the next cycle, and the first table read appears in that same cycle. Each level then spends at least one cycle requesting and one cycle waiting for data, plus any stall cycles the memory adds. The result pulse appears in the cycle after the edge that captured the deciding entry. The bench drives and samples only at falling edges. It follows the walk one cycle at a time, compares every accepted read address against a queue built by its own walk of the table image, and holds `busy` to its expected value on every clock. It compares the pulse contents on the cycle the pulse is seen and confirms that the pulse is gone one cycle later.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int unsigned IDX_W_DEF   = 10;
  localparam int unsigned OFFS_W_DEF  = 13;
  localparam int unsigned LEVELS_DEF  = 3;
  localparam int unsigned PFN_W_DEF   = 27;
  localparam int unsigned PTE_W_DEF   = 64;
  localparam int unsigned PFN_LSB_DEF = 32;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_READ   = 2'd2,
    FLT_WRITE  = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned LEVELS = 3,
  parameter int unsigned PA_W   = 40,
  parameter int unsigned LVL_W  = 2
) (
  input  logic [LEVELS*IDX_W-1:0] vpn,
  input  logic [LVL_W-1:0]        lvl,
  input  logic [PA_W-1:0]         base,
  output logic [PA_W-1:0]         addr
);
  localparam int unsigned VPN_W       = LEVELS * IDX_W;
  localparam int unsigned ENTRY_SHIFT = 3;

  logic [IDX_W-1:0] field [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_field
      assign field[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
    end
  endgenerate

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] tbl,
                                                 input logic [IDX_W-1:0] ix);
    return tbl + (PA_W'(ix) << ENTRY_SHIFT);
  endfunction

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i + 1)) idx_sel = field[i];
    end
  end

  assign addr = entry_addr(base, idx_sel);

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int unsigned PTE_W   = 64,
  parameter int unsigned PFN_W   = 27,
  parameter int unsigned PFN_LSB = 32,
  parameter int unsigned OFFS_W  = 13
) (
  input  logic [PTE_W-1:0]        pte,
  output logic                    present,
  output logic                    kr,
  output logic                    kw,
  output logic                    ur,
  output logic                    uw,
  output logic [PFN_W-1:0]        pfn,
  output logic [PFN_W+OFFS_W-1:0] next_base
);
  localparam int unsigned FLAG_W = 5;

  logic unused_bits;

  function automatic logic [PFN_W+OFFS_W-1:0] frame_to_base(input logic [PFN_W-1:0] f);
    return {f, {OFFS_W{1'b0}}};
  endfunction

  assign present   = pte[0];
  assign kr        = pte[1];
  assign kw        = pte[2];
  assign ur        = pte[3];
  assign uw        = pte[4];
  assign pfn       = pte[PFN_LSB +: PFN_W];
  assign next_base = frame_to_base(pfn);

  assign unused_bits = ^{pte[PTE_W-1:PFN_LSB+PFN_W], pte[PFN_LSB-1:FLAG_W]};

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic is_write,
  input  logic is_user,
  input  logic kr,
  input  logic kw,
  input  logic ur,
  input  logic uw,
  output logic allow,
  output flt_e deny_code
);
  function automatic logic granted(input logic wr, input logic usr,
                                   input logic k_r, input logic k_w,
                                   input logic u_r, input logic u_w);
    logic g;
    if (wr) g = usr ? u_w : k_w;
    else    g = usr ? u_r : k_r;
    return g;
  endfunction

  assign allow     = granted(is_write, is_user, kr, kw, ur, uw);
  assign deny_code = is_write ? FLT_WRITE : FLT_READ;

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned IDX_W   = IDX_W_DEF,
  parameter int unsigned OFFS_W  = OFFS_W_DEF,
  parameter int unsigned LEVELS  = LEVELS_DEF,
  parameter int unsigned PFN_W   = PFN_W_DEF,
  parameter int unsigned PTE_W   = PTE_W_DEF,
  parameter int unsigned PFN_LSB = PFN_LSB_DEF,
  localparam int unsigned VPN_W  = LEVELS * IDX_W,
  localparam int unsigned PA_W   = PFN_W + OFFS_W,
  localparam int unsigned LVL_W  = $clog2(LEVELS + 1),
  localparam int unsigned PERM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [PA_W-1:0]   ptbr,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic [PFN_W-1:0]  done_pfn,
  output logic [PERM_W-1:0] done_perm,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic [LVL_W-1:0]  fault_level
);

  walk_st_e          st_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [VPN_W-1:0]  vpn_q;
  logic              wr_q;
  logic              user_q;
  logic [PA_W-1:0]   base_q;
  logic              done_q;
  logic              fault_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [PERM_W-1:0] perm_q;
  flt_e              fcode_q;
  logic [LVL_W-1:0]  flvl_q;

  logic              pte_present;
  logic              pte_kr;
  logic              pte_kw;
  logic              pte_ur;
  logic              pte_uw;
  logic [PFN_W-1:0]  pte_pfn;
  logic [PA_W-1:0]   pte_next_base;
  logic              perm_allow;
  flt_e              perm_deny;

  // Named internal events, shared with the bound checker.
  logic walk_start;
  logic mem_fire;
  logic rsp_take;
  logic at_leaf;
  logic entry_absent;
  logic leaf_decide;

  assign walk_start   = req_valid && (st_q == ST_IDLE);
  assign mem_fire     = (st_q == ST_REQ) && mem_req_ready;
  assign rsp_take     = (st_q == ST_WAIT) && mem_rsp_valid;
  assign at_leaf      = (lvl_q == LVL_W'(LEVELS));
  assign entry_absent = rsp_take && !pte_present;
  assign leaf_decide  = rsp_take && pte_present && at_leaf;

  ptw_addr_gen #(
    .IDX_W  (IDX_W),
    .LEVELS (LEVELS),
    .PA_W   (PA_W),
    .LVL_W  (LVL_W)
  ) u_addr (
    .vpn  (vpn_q),
    .lvl  (lvl_q),
    .base (base_q),
    .addr (mem_req_addr)
  );

  ptw_pte_decode #(
    .PTE_W   (PTE_W),
    .PFN_W   (PFN_W),
    .PFN_LSB (PFN_LSB),
    .OFFS_W  (OFFS_W)
  ) u_dec (
    .pte       (mem_rsp_data),
    .present   (pte_present),
    .kr        (pte_kr),
    .kw        (pte_kw),
    .ur        (pte_ur),
    .uw        (pte_uw),
    .pfn       (pte_pfn),
    .next_base (pte_next_base)
  );

  ptw_perm_check u_perm (
    .is_write  (wr_q),
    .is_user   (user_q),
    .kr        (pte_kr),
    .kw        (pte_kw),
    .ur        (pte_ur),
    .uw        (pte_uw),
    .allow     (perm_allow),
    .deny_code (perm_deny)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      vpn_q   <= '0;
      wr_q    <= 1'b0;
      user_q  <= 1'b0;
      base_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      pfn_q   <= '0;
      perm_q  <= '0;
      fcode_q <= FLT_NONE;
      flvl_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      fcode_q <= FLT_NONE;
      flvl_q  <= '0;
      unique case (st_q)
        ST_IDLE: begin
          if (walk_start) begin
            vpn_q  <= req_vpn;
            wr_q   <= req_write;
            user_q <= req_user;
            base_q <= ptbr;
            lvl_q  <= LVL_W'(1);
            st_q   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_fire) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (entry_absent) begin
            fault_q <= 1'b1;
            fcode_q <= FLT_ABSENT;
            flvl_q  <= lvl_q;
            st_q    <= ST_IDLE;
          end else if (leaf_decide) begin
            if (perm_allow) begin
              done_q <= 1'b1;
              pfn_q  <= pte_pfn;
              perm_q <= {pte_uw, pte_ur, pte_kw, pte_kr};
            end else begin
              fault_q <= 1'b1;
              fcode_q <= perm_deny;
              flvl_q  <= lvl_q;
            end
            st_q <= ST_IDLE;
          end else if (rsp_take) begin
            base_q <= pte_next_base;
            lvl_q  <= lvl_q + LVL_W'(1);
            st_q   <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ);
  assign done_valid    = done_q;
  assign done_pfn      = pfn_q;
  assign done_perm     = perm_q;
  assign fault_valid   = fault_q;
  assign fault_code    = fcode_q;
  assign fault_level   = flvl_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned LEVELS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             walk_start,
  input logic             entry_absent,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             done_valid,
  input logic             fault_valid,
  input logic [1:0]       fault_code,
  input logic [LVL_W-1:0] fault_level
);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> busy);

  p_no_mem_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid || fault_valid) |-> !busy);

  p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_absent |=> (fault_valid && fault_code == 2'd1));

  p_perm_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_code != 2'd1) |-> (fault_level == LVL_W'(LEVELS)));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && fault_valid));

  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid || fault_valid) |=> !(done_valid || fault_valid));

endmodule

bind ptw_walker ptw_walker_chk #(
  .PA_W   (PA_W),
  .LVL_W  (LVL_W),
  .LEVELS (LEVELS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .walk_start    (walk_start),
  .entry_absent  (entry_absent),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done_valid    (done_valid),
  .fault_valid   (fault_valid),
  .fault_code    (fault_code),
  .fault_level   (fault_level)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [29:0] req_vpn = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [39:0] ptbr = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [39:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [26:0] done_pfn;
  logic [3:0]  done_perm;
  logic        fault_valid;
  logic [1:0]  fault_code;
  logic [1:0]  fault_level;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ptw_walker u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_vpn (req_vpn),
    .req_write (req_write), .req_user (req_user), .ptbr (ptbr),
    .busy (busy),
    .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
    .done_valid (done_valid), .done_pfn (done_pfn), .done_perm (done_perm),
    .fault_valid (fault_valid), .fault_code (fault_code), .fault_level (fault_level)
  );

  logic [63:0] pt_mem [logic [39:0]];

  localparam logic [39:0] ROOT_A = 40'h00_0010_0000;
  localparam logic [39:0] ROOT_B = 40'h00_0020_0000;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [26:0] pfn, input logic [4:0] flags);
    return (64'(pfn) << 32) | 64'(flags);
  endfunction

  function automatic logic [63:0] rd(input logic [39:0] a);
    if (pt_mem.exists(a)) return pt_mem[a];
    return 64'd0;
  endfunction

  function automatic logic [29:0] va(input int a, input int b, input int c);
    return {a[9:0], b[9:0], c[9:0]};
  endfunction

  task automatic run_walk(input logic [29:0] vpn, input bit wr, input bit usr,
                          input logic [39:0] root, input bit stall, input int lat,
                          input bit poke, input string tag);
    logic [39:0] exp_q[$];
    logic [39:0] tbl;
    logic [63:0] ent;
    bit   exp_fault;
    int   exp_code, exp_lvl;
    logic [26:0] exp_pfn;
    logic [3:0]  exp_perm;
    bit   fin, busy_ok, extra;
    int   rcnt;
    logic [63:0] pend;
    bit   ok_perm;

    // Behavioural walk of the table image.
    tbl = root; exp_fault = 0; exp_code = 0; exp_lvl = 0; exp_pfn = '0; exp_perm = '0;
    for (int l = 1; l <= 3; l++) begin
      logic [9:0] ix;
      ix = vpn[29 - (l-1)*10 -: 10];
      exp_q.push_back(tbl + 40'(ix) * 8);
      ent = rd(tbl + 40'(ix) * 8);
      if (!ent[0]) begin exp_fault = 1; exp_code = 1; exp_lvl = l; break; end
      if (l < 3) tbl = 40'(ent[58:32]) * 40'd8192;
      else begin
        if (wr) ok_perm = usr ? ent[4] : ent[2];
        else    ok_perm = usr ? ent[3] : ent[1];
        if (ok_perm) begin exp_pfn = ent[58:32]; exp_perm = ent[4:1]; end
        else begin exp_fault = 1; exp_code = wr ? 3 : 2; exp_lvl = 3; end
      end
    end

    @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0, "R9", "idle before walk", busy, 0);
    req_valid = 1; req_vpn = vpn; req_write = wr; req_user = usr; ptbr = root;
    fin = 0; busy_ok = 1; extra = 0; rcnt = 0; pend = '0;
    for (int c = 0; c < 400 && !fin; c++) begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (done_valid || fault_valid) begin
        fin = 1;
        chk(busy === 1'b0, "R9", "busy during pulse", busy, 0);
        chk(!(done_valid && fault_valid), "R10", "both pulses", {done_valid, fault_valid}, 0);
        if (exp_fault) begin
          chk(fault_valid === 1'b1, tag, "fault pulse", fault_valid, 1);
          chk(fault_code == 2'(exp_code), tag, "fault code", fault_code, exp_code);
          chk(fault_level == 2'(exp_lvl), tag, "fault level", fault_level, exp_lvl);
        end else begin
          chk(done_valid === 1'b1, tag, "done pulse", done_valid, 1);
          chk(done_pfn == exp_pfn, "R8", "frame number", done_pfn, exp_pfn);
          chk(done_perm == exp_perm, "R8", "perm bits", done_perm, exp_perm);
        end
      end else begin
        if (busy !== 1'b1 || req_ready !== 1'b0) busy_ok = 0;
        if (poke && c < 2) begin
          req_valid = 1; req_vpn = ~vpn; req_write = ~wr; req_user = ~usr;
          ptbr = root ^ 40'h2000;
        end else begin
          req_valid = 0;
        end
        if (rcnt > 0) begin
          rcnt--;
          if (rcnt == 0) begin mem_rsp_valid = 1; mem_rsp_data = pend; end
        end
        mem_req_ready = stall ? (c % 3 == 2) : 1'b1;
        if (mem_req_valid && mem_req_ready) begin
          if (exp_q.size() == 0) extra = 1;
          else begin
            logic [39:0] ea;
            ea = exp_q.pop_front();
            chk(mem_req_addr == ea, "R2", "entry address", mem_req_addr, ea);
          end
          pend = rd(mem_req_addr);
          rcnt = lat;
        end
      end
    end
    req_valid = 0;
    if (!fin) chk(0, tag, "watchdog: no result pulse", 0, 1);
    chk(busy_ok, "R9", "busy/ready held during walk", busy_ok, 1);
    chk(!extra && exp_q.size() == 0, "R4", "read count per walk", exp_q.size(), 0);
    @(negedge clk);
    chk(!done_valid && !fault_valid, "R10", "pulse width", {done_valid, fault_valid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Flags: bit0 present, bit1 kr, bit2 kw, bit3 ur, bit4 uw.
    pt_mem[ROOT_A + 5*8]          = mk(27'h200, 5'b00001);
    pt_mem[ROOT_A + 6*8]          = mk(27'h250, 5'b11110);
    pt_mem[40'h40_0000 + 7*8]     = mk(27'h300, 5'b00001);
    pt_mem[40'h40_0000 + 8*8]     = mk(27'h310, 5'b11110);
    pt_mem[40'h60_0000 + 9*8]     = mk(27'h1ABCD, 5'b11111);
    pt_mem[40'h60_0000 + 10*8]    = mk(27'h2222, 5'b01001);
    pt_mem[40'h60_0000 + 11*8]    = mk(27'h3333, 5'b00101);
    pt_mem[40'h60_0000 + 12*8]    = mk(27'h4444, 5'b11110);
    pt_mem[40'h60_0000 + 13*8]    = mk(27'h5555, 5'b10011);
    pt_mem[ROOT_A + 1023*8]       = mk(27'h400, 5'b00001);
    pt_mem[40'h80_0000 + 1023*8]  = mk(27'h401, 5'b00001);
    pt_mem[40'h80_2000 + 1023*8]  = mk(27'h7FFFFFF, 5'b11001);
    pt_mem[ROOT_B]                = mk(27'h500, 5'b00001);
    pt_mem[40'hA0_0000]           = mk(27'h501, 5'b00001);
    pt_mem[40'hA0_2000]           = mk(27'h12345, 5'b00111);

    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && mem_req_valid === 1'b0, "R1", "reset busy/mem", {busy, mem_req_valid}, 0);
    chk(done_valid === 1'b0 && fault_valid === 1'b0, "R1", "reset pulses", {done_valid, fault_valid}, 0);
    chk(req_ready === 1'b1, "R1", "reset ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    run_walk(va(5,7,9),   0, 0, ROOT_A, 0, 1, 0, "R8");
    run_walk(va(5,7,9),   1, 1, ROOT_A, 0, 2, 0, "R3");
    run_walk(va(5,7,10),  0, 1, ROOT_A, 0, 1, 0, "R6");
    run_walk(va(5,7,10),  0, 0, ROOT_A, 1, 1, 0, "R6");
    run_walk(va(5,7,10),  1, 1, ROOT_A, 0, 1, 0, "R7");
    run_walk(va(5,7,11),  1, 0, ROOT_A, 1, 2, 0, "R7");
    run_walk(va(5,7,11),  0, 0, ROOT_A, 0, 1, 0, "R6");
    run_walk(va(5,7,13),  1, 0, ROOT_A, 0, 1, 0, "R7");
    run_walk(va(5,7,13),  1, 1, ROOT_A, 0, 3, 0, "R7");
    run_walk(va(5,7,12),  0, 0, ROOT_A, 0, 1, 0, "R5");
    run_walk(va(5,8,0),   0, 0, ROOT_A, 1, 1, 0, "R5");
    run_walk(va(6,0,0),   1, 1, ROOT_A, 1, 3, 0, "R5");
    run_walk(va(1023,1023,1023), 0, 1, ROOT_A, 1, 2, 0, "R2");
    run_walk(va(0,0,0),   1, 0, ROOT_B, 0, 1, 1, "R9");
    run_walk(va(5,7,9),   0, 1, ROOT_A, 1, 2, 1, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule